// File: doc/BRIEF.md
# DMA and Interrupt Priority Arbiter

This block decides, once per instruction boundary, which pending peripheral request the processor services next. Each of several peripheral channels can raise an interrupt request, a DMA request, or both. Every request carries one of eight priority levels, and level 0 is the most urgent. Interrupts and DMA share one priority scale and are weighed in a single arbitration step. Each kind is tested against the current processor priority level (CPL) with its own threshold.

A request pulse is latched into a pending slot together with its level. The slot stays pending until that request is granted. When the instruction-end strobe is high and some pending request qualifies, the block issues a one-cycle grant. The grant names the channel, the kind and the level. An accepted interrupt moves the CPL to its own level. A DMA transfer leaves the CPL alone. A separate write port lets the processor restore the CPL when it returns from an interrupt handler.

Top module: `prio_dma_irq_arb`

## Requirements
- R1: After reset no request is pending, `grant_vld` is 0 and `cpl` holds 7, the least urgent level.
- R2: A request pulse on a channel with nothing pending of that kind latches the level on that cycle. While the slot stays pending, later pulses on it are ignored, and so is their level.
- R3: A grant appears only in the cycle after `instr_end` was high. It lasts exactly one cycle, and each strobe gives at most one grant.
- R4: An interrupt qualifies only when its level is numerically lower than the CPL. An interrupt at a level equal to the CPL is not granted.
- R5: A DMA request qualifies when its level is lower than or equal to the CPL. With the CPL at 0, only DMA requests are granted.
- R6: Among qualifying requests, the numerically lowest level wins, whatever its kind.
- R7: When a DMA request and an interrupt request tie on level, the DMA request wins (`grant_is_dma` = 1 means DMA).
- R8: Among requests of the same kind and level, the lowest channel index wins.
- R9: A granted interrupt loads its level into the CPL on the grant edge. A granted DMA request leaves the CPL unchanged.
- R10: `cpl_wr_en` loads `cpl_wr_val` into the CPL on the next edge. When it coincides with an interrupt grant, the written value wins. That grant was still judged against the old CPL.
- R11: A pending request that does not qualify stays pending. It is granted at a later strobe once the CPL allows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_CH | Interrupt request pulses, one per channel |
| irq_lvl | input | NUM_CH*3 | Interrupt level per channel, channel c in bits [3c+2:3c] |
| dma_req | input | NUM_CH | DMA request pulses, one per channel |
| dma_lvl | input | NUM_CH*3 | DMA level per channel, channel c in bits [3c+2:3c] |
| instr_end | input | 1 | High for one cycle when the current instruction completes |
| cpl_wr_en | input | 1 | Load the CPL from `cpl_wr_val` |
| cpl_wr_val | input | 3 | New CPL value |
| grant_vld | output | 1 | One-cycle grant pulse |
| grant_is_dma | output | 1 | 1 for a DMA grant, 0 for an interrupt grant |
| grant_ch | output | CH_W | Granted channel index |
| grant_lvl | output | 3 | Level of the granted request |
| cpl | output | 3 | Current processor priority level |

## Verification
The hardest case to reach is a coincidence on a single strobe. An interrupt grant must occur on the same edge as a CPL write, and the grant must be judged against the old CPL while the new value ends up in the register. The stimulus first parks an interrupt below an unreachable CPL of 0. It then writes a permissive CPL, and finally drives the strobe and a second CPL write in the same cycle. The ignored re-pulse of a pending slot is also hard to observe. It is shown by re-raising a blocked interrupt with a different level, then lowering the CPL barrier and checking that the grant still reports the first level.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_LEAST = lvl_t'(NUM_LVL - 1);

    typedef struct packed {
        logic pend;
        lvl_t lvl;
    } slot_t;
endpackage

// File: rtl/prio_arb_pend_bank.sv
module prio_arb_pend_bank
    import prio_arb_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       req_i,
    input  logic [NUM_CH*LVL_W-1:0] lvl_i,
    input  logic [NUM_CH-1:0]       clr_i,
    output logic [NUM_CH-1:0]       pend_o,
    output logic [NUM_CH*LVL_W-1:0] lvl_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_i[g]) begin
                slot_d.pend = 1'b0;
            end
            // a free slot (or one being granted now) takes a new pulse
            if (req_i[g] && (!slot_q.pend || clr_i[g])) begin
                slot_d.pend = 1'b1;
                slot_d.lvl  = lvl_i[g*LVL_W +: LVL_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign pend_o[g]                = slot_q.pend;
        assign lvl_o[g*LVL_W +: LVL_W]  = slot_q.lvl;
    end
endmodule

// File: rtl/prio_arb_select.sv
module prio_arb_select
    import prio_arb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0]       dma_pend_i,
    input  logic [NUM_CH*LVL_W-1:0] dma_lvl_i,
    input  logic [NUM_CH-1:0]       irq_pend_i,
    input  logic [NUM_CH*LVL_W-1:0] irq_lvl_i,
    input  lvl_t                    cpl_i,
    output logic                    win_vld_o,
    output logic                    win_dma_o,
    output logic [CH_W-1:0]         win_ch_o,
    output lvl_t                    win_lvl_o
);
    // Scan order DMA ch0..N-1 then IRQ ch0..N-1; only a strictly
    // better level replaces the holder, so earlier entries win ties.
    always_comb begin
        win_vld_o = 1'b0;
        win_dma_o = 1'b0;
        win_ch_o  = '0;
        win_lvl_o = LVL_LEAST;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dma_pend_i[i] && (dma_lvl_i[i*LVL_W +: LVL_W] <= cpl_i) &&
                (!win_vld_o || (dma_lvl_i[i*LVL_W +: LVL_W] < win_lvl_o))) begin
                win_vld_o = 1'b1;
                win_dma_o = 1'b1;
                win_ch_o  = CH_W'(i);
                win_lvl_o = dma_lvl_i[i*LVL_W +: LVL_W];
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (irq_pend_i[i] && (irq_lvl_i[i*LVL_W +: LVL_W] < cpl_i) &&
                (!win_vld_o || (irq_lvl_i[i*LVL_W +: LVL_W] < win_lvl_o))) begin
                win_vld_o = 1'b1;
                win_dma_o = 1'b0;
                win_ch_o  = CH_W'(i);
                win_lvl_o = irq_lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/prio_dma_irq_arb.sv
module prio_dma_irq_arb
    import prio_arb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       irq_req,
    input  logic [NUM_CH*LVL_W-1:0] irq_lvl,
    input  logic [NUM_CH-1:0]       dma_req,
    input  logic [NUM_CH*LVL_W-1:0] dma_lvl,
    input  logic                    instr_end,
    input  logic                    cpl_wr_en,
    input  logic [LVL_W-1:0]        cpl_wr_val,
    output logic                    grant_vld,
    output logic                    grant_is_dma,
    output logic [CH_W-1:0]         grant_ch,
    output logic [LVL_W-1:0]        grant_lvl,
    output logic [LVL_W-1:0]        cpl
);
    typedef struct packed {
        logic            gvld;
        logic            gdma;
        logic [CH_W-1:0] gch;
        lvl_t            glvl;
        lvl_t            cpl;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_CH-1:0]       dma_pend, irq_pend, dma_clr, irq_clr, sel_mask;
    logic [NUM_CH*LVL_W-1:0] dma_plvl, irq_plvl;
    logic                    win_vld, win_dma, fire;
    logic [CH_W-1:0]         win_ch;
    lvl_t                    win_lvl;

    prio_arb_pend_bank #(.NUM_CH(NUM_CH)) u_dma_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (dma_req),
        .lvl_i  (dma_lvl),
        .clr_i  (dma_clr),
        .pend_o (dma_pend),
        .lvl_o  (dma_plvl)
    );

    prio_arb_pend_bank #(.NUM_CH(NUM_CH)) u_irq_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .lvl_i  (irq_lvl),
        .clr_i  (irq_clr),
        .pend_o (irq_pend),
        .lvl_o  (irq_plvl)
    );

    prio_arb_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_select (
        .dma_pend_i (dma_pend),
        .dma_lvl_i  (dma_plvl),
        .irq_pend_i (irq_pend),
        .irq_lvl_i  (irq_plvl),
        .cpl_i      (st_q.cpl),
        .win_vld_o  (win_vld),
        .win_dma_o  (win_dma),
        .win_ch_o   (win_ch),
        .win_lvl_o  (win_lvl)
    );

    assign fire     = instr_end && win_vld;
    assign sel_mask = NUM_CH'(1) << win_ch;
    assign dma_clr  = (fire &&  win_dma) ? sel_mask : '0;
    assign irq_clr  = (fire && !win_dma) ? sel_mask : '0;

    always_comb begin
        st_d      = st_q;
        st_d.gvld = 1'b0;
        if (fire) begin
            st_d.gvld = 1'b1;
            st_d.gdma = win_dma;
            st_d.gch  = win_ch;
            st_d.glvl = win_lvl;
            if (!win_dma) begin
                st_d.cpl = win_lvl;
            end
        end
        if (cpl_wr_en) begin
            st_d.cpl = cpl_wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cpl <= LVL_LEAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld    = st_q.gvld;
    assign grant_is_dma = st_q.gdma;
    assign grant_ch     = st_q.gch;
    assign grant_lvl    = st_q.glvl;
    assign cpl          = st_q.cpl;
endmodule

// File: rtl/prio_dma_irq_arb_chk.sv
module prio_dma_irq_arb_chk
    import prio_arb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_end,
    input logic             cpl_wr_en,
    input logic [LVL_W-1:0] cpl_wr_val,
    input logic             grant_vld,
    input logic             grant_is_dma,
    input logic [CH_W-1:0]  grant_ch,
    input logic [LVL_W-1:0] grant_lvl,
    input logic [LVL_W-1:0] cpl
);
    a_r3_grant_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> $past(instr_end));

    a_r3_grant_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (int'(grant_ch) < NUM_CH));

    a_r4_irq_strict: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !grant_is_dma) |-> (grant_lvl < $past(cpl)));

    a_r5_dma_at_or_above: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_is_dma) |-> (grant_lvl <= $past(cpl)));

    a_r5_top_only_dma: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && ($past(cpl) == '0)) |-> grant_is_dma);

    a_r9_dma_keeps_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_is_dma && !$past(cpl_wr_en)) |-> $stable(cpl));

    a_r9_irq_loads_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !grant_is_dma && !$past(cpl_wr_en)) |-> (cpl == grant_lvl));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpl_wr_en) |-> (cpl == $past(cpl_wr_val)));
endmodule

bind prio_dma_irq_arb prio_dma_irq_arb_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_end    (instr_end),
    .cpl_wr_en    (cpl_wr_en),
    .cpl_wr_val   (cpl_wr_val),
    .grant_vld    (grant_vld),
    .grant_is_dma (grant_is_dma),
    .grant_ch     (grant_ch),
    .grant_lvl    (grant_lvl),
    .cpl          (cpl)
);

// File: tb/prio_dma_irq_arb_test.sv
module prio_dma_irq_arb_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int LW         = 3;
    localparam int CW         = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    irq_req = '0;
    logic [NCH*LW-1:0] irq_lvl = '0;
    logic [NCH-1:0]    dma_req = '0;
    logic [NCH*LW-1:0] dma_lvl = '0;
    logic              instr_end = 1'b0;
    logic              cpl_wr_en = 1'b0;
    logic [LW-1:0]     cpl_wr_val = '0;
    logic              grant_vld, grant_is_dma;
    logic [CW-1:0]     grant_ch;
    logic [LW-1:0]     grant_lvl, cpl;

    prio_dma_irq_arb #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .dma_req(dma_req), .dma_lvl(dma_lvl), .instr_end(instr_end),
        .cpl_wr_en(cpl_wr_en), .cpl_wr_val(cpl_wr_val), .grant_vld(grant_vld),
        .grant_is_dma(grant_is_dma), .grant_ch(grant_ch), .grant_lvl(grant_lvl),
        .cpl(cpl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    vld;
        bit    dma;
        int    ch;
        int    lvl;
        int    cpl;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   end_seen = 1'b0;
    bit   done = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: compares the outcome of every strobe against the scoreboard
    always @(posedge clk) end_seen <= rst_n && instr_end;

    always @(negedge clk) begin
        if (rst_n) begin
            if (end_seen) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected strobe result", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(grant_vld == e.vld, e.req, "grant_vld", int'(grant_vld), int'(e.vld));
                    if (e.vld && grant_vld) begin
                        check(grant_is_dma == e.dma, e.req, "grant_is_dma", int'(grant_is_dma), int'(e.dma));
                        check(int'(grant_ch) == e.ch, e.req, "grant_ch", int'(grant_ch), e.ch);
                        check(int'(grant_lvl) == e.lvl, e.req, "grant_lvl", int'(grant_lvl), e.lvl);
                    end
                    check(int'(cpl) == e.cpl, e.req, "cpl", int'(cpl), e.cpl);
                end
            end else begin
                check(!grant_vld, "R3", "grant without strobe", int'(grant_vld), 0);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        irq_req   = '0;
        dma_req   = '0;
        instr_end = 1'b0;
        cpl_wr_en = 1'b0;
    endtask

    task automatic set_irq(int ch, int lvl);
        irq_req[ch] = 1'b1;
        irq_lvl[ch*LW +: LW] = LW'(lvl);
    endtask

    task automatic set_dma(int ch, int lvl);
        dma_req[ch] = 1'b1;
        dma_lvl[ch*LW +: LW] = LW'(lvl);
    endtask

    task automatic strobe(bit vld, bit dma, int ch, int lvl, int c, string req);
        exp_t e;
        e.vld = vld; e.dma = dma; e.ch = ch; e.lvl = lvl; e.cpl = c; e.req = req;
        exp_q.push_back(e);
        instr_end = 1'b1;
        tick();
    endtask

    task automatic wr_cpl(int v);
        cpl_wr_en  = 1'b1;
        cpl_wr_val = LW'(v);
        tick();
        check(int'(cpl) == v, "R10", "cpl after write", int'(cpl), v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!grant_vld, "R1", "grant_vld after reset", int'(grant_vld), 0);
        check(int'(cpl) == 7, "R1", "cpl after reset", int'(cpl), 7);
        // R1/R3: strobe with nothing pending
        strobe(0, 0, 0, 0, 7, "R1");

        // R4/R9: interrupt below CPL accepted, CPL follows
        set_irq(2, 3); tick();
        strobe(1, 0, 2, 3, 3, "R9");
        // R4: interrupt equal to CPL refused
        set_irq(1, 3); tick();
        strobe(0, 0, 0, 0, 3, "R4");
        // R5/R9: DMA equal to CPL accepted, CPL kept
        set_dma(4, 3); tick();
        strobe(1, 1, 4, 3, 3, "R5");

        // R7: tie at level 3, DMA first; R11: interrupt waits
        wr_cpl(5);
        set_dma(6, 3); tick();
        strobe(1, 1, 6, 3, 5, "R7");
        strobe(1, 0, 1, 3, 3, "R11");

        // R8: lowest channel among equal DMA requests
        wr_cpl(7);
        set_dma(5, 2); set_dma(3, 2); set_irq(0, 4); tick();
        strobe(1, 1, 3, 2, 7, "R8");
        strobe(1, 1, 5, 2, 7, "R8");
        strobe(1, 0, 0, 4, 4, "R9");

        // R6: more urgent interrupt beats less urgent DMA
        wr_cpl(7);
        set_irq(7, 1); set_dma(0, 6); tick();
        strobe(1, 0, 7, 1, 1, "R6");
        strobe(0, 0, 0, 0, 1, "R11");
        wr_cpl(7);
        strobe(1, 1, 0, 6, 7, "R11");

        // R5: CPL 0 admits only DMA
        wr_cpl(0);
        set_irq(2, 0); set_dma(1, 0); tick();
        strobe(1, 1, 1, 0, 0, "R5");
        strobe(0, 0, 0, 0, 0, "R5");

        // R2: re-pulse of pending slot with new level is ignored
        set_irq(2, 5); tick();
        wr_cpl(7);
        strobe(1, 0, 2, 0, 0, "R2");

        // R10: CPL write on the same edge as an interrupt grant
        set_irq(3, 2); tick();
        strobe(0, 0, 0, 0, 0, "R4");
        wr_cpl(6);
        cpl_wr_en  = 1'b1;
        cpl_wr_val = 3'd4;
        strobe(1, 0, 3, 2, 4, "R10");
        strobe(0, 0, 0, 0, 4, "R3");

        tick(); tick();
        check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule